// File: doc/BRIEF.md
# Byte-Level 16550-Style Serial Port Register File

This block models the register set of a 16550-compatible serial port as a host sees it through an eight-location, byte-wide port with separate read and write strobes. Characters move as whole bytes. Received bytes arrive on a strobed byte input and fill a receive queue. Transmitted bytes leave on a one-cycle strobed byte output. Bit timing, baud generation, parity and framing are not part of the block. The divisor latches are kept only as storage that software can read and write.

The block decodes the usual register offsets: data, interrupt enable, interrupt identification and FIFO control, line control, modem control, line status, modem status and scratch. Setting the divisor-access bit of the line control register remaps offsets 0 and 1 to the divisor bytes. A single level-sensitive interrupt output follows a fixed four-level priority among the pending causes. Several reads have side effects. Identification reads can retire a pending transmit-empty cause. Line-status reads clear overrun. Modem-status reads clear the change flags. The modem control register has a loopback mode. In that mode, transmitted bytes go back into the receive queue, and the modem control outputs appear as modem status inputs, which also raises change flags.

Read data is registered: the value of a read issued in one cycle appears on `rdata` after that clock edge. If both strobes are high in the same cycle, the cycle is treated as a write only.

Top module: `serial_port_regs`

## Requirements
- R1: After reset the divisor is 12 (low byte 0x0C, high byte 0x00), the interrupt enable, line control and modem control registers read 0, identification reads 0x01, line status reads 0x60 and `irq` is low.
- R2: While line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. While it is 0, these offsets reach the data path and the interrupt enable register.
- R3: The interrupt enable register keeps only bits 3:0 of a write (0 receive data, 1 transmit empty, 2 line status, 3 modem status). The modem control register keeps only bits 4:0 (0 DTR, 1 RTS, 2 OUT1, 3 OUT2, 4 loopback). Line control and scratch keep all 8 bits.
- R4: A data write with loopback off produces `tx_valid` high for exactly one cycle, in the cycle after the write, with `tx_byte` equal to the written byte. Every data write sets the transmit-empty pending flag.
- R5: Identification bits 3:0 report the highest-priority enabled cause: overrun with bit 2 enabled gives 0x6; a non-empty receive queue with bit 0 enabled gives 0xC; transmit-empty pending with bit 1 enabled gives 0x2; any modem change flag with bit 3 enabled gives 0x0; otherwise 0x1.
- R6: An identification read that reports 0x2 clears the transmit-empty pending flag. Identification bits 7:6 read 11 while the FIFO is enabled and 00 otherwise.
- R7: The receive queue holds 1 byte after reset. A FIFO control write that changes bit 0 empties the queue and sets its capacity to 16 bytes (bit 0 set) or 1 byte (bit 0 clear). A write with bit 0 clear zeroes the stored FIFO control. A write with bits 0 and 1 set empties the queue.
- R8: A byte pushed into a full queue is lost and sets overrun. A line status read returns bit 6 and bit 5 set, bit 0 set when the queue is non-empty, and bit 1 equal to overrun; overrun is cleared after the read.
- R9: With loopback on, a data write enters the receive queue instead of `tx_byte`, external receive bytes are dropped, and the modem status bits follow the modem control bits: RTS to bit 4, DTR to bit 5, OUT1 to bit 6 and OUT2 to bit 7. With loopback off these status bits are 0.
- R10: A change of modem status bit 4, 5 or 7 on a modem control write sets change flag bit 0, 1 or 3 respectively, and a 1-to-0 change of bit 6 sets bit 2. The change flags survive later modem control writes and are cleared by a modem status read.
- R11: Writes to the line status and modem status offsets change nothing.
- R12: `irq` is high exactly when the reported cause is not 0x1. It follows every access and every receive push without extra delay.
- R13: A data read from an empty receive queue returns 0xFF and leaves the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmitted byte strobe |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest condition to reach is having all four interrupt causes pending together, so that the priority order can be seen one level at a time. The block has no modem input pins, so modem change flags only come from loopback. The stimulus first overruns the one-byte queue, then makes a transmit write, then turns loopback on with RTS so that a change flag is set. After that, alternating line status, data, identification and modem status reads retire the causes one by one, and each identification read must show the next cause in the order. Filling the 16-deep queue exactly to its edge, and then one byte past it, checks the capacity switch and the overrun.

// File: rtl/serport_pkg.sv
// Package: register offsets and interrupt cause codes shared by the serial
// port register file and its helpers. Assumes an 8-location byte map.
package serport_pkg;
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_IIR  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_MSR  = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    localparam logic [3:0] CAUSE_NONE  = 4'h1;
    localparam logic [3:0] CAUSE_LINE  = 4'h6;
    localparam logic [3:0] CAUSE_RXTO  = 4'hC;
    localparam logic [3:0] CAUSE_THRE  = 4'h2;
    localparam logic [3:0] CAUSE_MODEM = 4'h0;
endpackage

// File: rtl/serport_rxq.sv
// Receive queue: circular byte buffer whose usable capacity is either one
// entry or DEPTH entries, chosen by deep_i. Assumes DEPTH is a power of two
// so the pointers wrap naturally. A clear wins over a push in the same cycle.
module serport_rxq #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         deep_i,
    input  logic                         clear_i,
    input  logic                         push_i,
    input  logic [DATA_W-1:0]            push_data_i,
    input  logic                         pop_i,
    output logic [DATA_W-1:0]            head_o,
    output logic                         empty_o,
    output logic                         overflow_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt, limit;
    logic              full, do_pop, do_push;

    // Capacity and handshake decisions for this cycle.
    always_comb begin
        limit      = deep_i ? CNT_W'(DEPTH) : CNT_W'(1);
        full       = (cnt >= limit);
        empty_o    = (cnt == '0);
        do_pop     = pop_i && !empty_o;
        do_push    = push_i && (!full || do_pop);
        overflow_o = push_i && full && !do_pop && !clear_i;
        head_o     = store[rd_ptr];
        count_o    = cnt;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Byte storage, written at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !clear_i) store[wr_ptr] <= push_data_i;
    end
endmodule

// File: rtl/serport_modem.sv
// Modem control and status: holds the modem control register, builds the
// status bits (loopback mirror only, no external modem pins) and keeps the
// sticky change flags until a status read clears them.
module serport_modem (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_mcr_i,
    input  logic [7:0] wdata_i,
    input  logic       rd_msr_i,
    output logic [7:0] mcr_o,
    output logic [7:0] msr_o
);
    logic [3:0] nxt_stat;   // {dcd, ri, dsr, cts}
    logic [3:0] nxt_delta;  // {ddcd, teri, ddsr, dcts}

    // New status and change flags implied by the incoming control byte.
    always_comb begin
        nxt_stat  = wdata_i[4] ? {wdata_i[3], wdata_i[2], wdata_i[0], wdata_i[1]} : 4'b0;
        nxt_delta[0] = nxt_stat[0] ^ msr_o[4];
        nxt_delta[1] = nxt_stat[1] ^ msr_o[5];
        nxt_delta[2] = msr_o[6] && !nxt_stat[2];
        nxt_delta[3] = nxt_stat[3] ^ msr_o[7];
    end

    // Control register capture and status/flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcr_o <= 8'h00;
            msr_o <= 8'h00;
        end else if (wr_mcr_i) begin
            mcr_o <= wdata_i & 8'h1F;
            msr_o <= {nxt_stat, msr_o[3:0] | nxt_delta};
        end else if (rd_msr_i) begin
            msr_o[3:0] <= 4'h0;
        end
    end
endmodule

// File: rtl/serport_cause.sv
// Interrupt cause selector: fixed-priority choice among line status,
// receive data, transmit empty and modem change, gated by the enables.
module serport_cause
    import serport_pkg::*;
(
    input  logic [3:0] ier_i,
    input  logic       overrun_i,
    input  logic       rx_ready_i,
    input  logic       thre_pend_i,
    input  logic       modem_chg_i,
    output logic [3:0] cause_o,
    output logic       active_o
);
    // Priority encode the pending causes.
    always_comb begin
        if (overrun_i && ier_i[2])        cause_o = CAUSE_LINE;
        else if (rx_ready_i && ier_i[0])  cause_o = CAUSE_RXTO;
        else if (thre_pend_i && ier_i[1]) cause_o = CAUSE_THRE;
        else if (modem_chg_i && ier_i[3]) cause_o = CAUSE_MODEM;
        else                              cause_o = CAUSE_NONE;
        active_o = (cause_o != CAUSE_NONE);
    end
endmodule

// File: rtl/serial_port_regs.sv
// Top: 16550-style register file over a byte host port. Decodes accesses,
// owns the divisor, enable, line control, FIFO control and scratch
// registers, overrun and transmit-empty flags, and the registered read
// data. Assumes one access per cycle; simultaneous strobes act as a write.
module serial_port_regs
    import serport_pkg::*;
#(
    parameter int REF_CLK_HZ   = 1843200,
    parameter int DEFAULT_BAUD = 9600,
    parameter int FIFO_DEPTH   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    output logic       irq
);
    localparam int          DIV_INT   = REF_CLK_HZ / DEFAULT_BAUD / 16;
    localparam logic [15:0] DIV_RESET = DIV_INT[15:0];
    localparam int          CNT_W     = $clog2(FIFO_DEPTH + 1);

    logic [7:0] dll, dlm, ier, lcr, scr, fcr;
    logic [7:0] mcr, msr;
    logic       lsr_oe, thre_pend;
    logic       dlab, loop_on, rd_any;
    logic       wr_thr, wr_dll, wr_dlm, wr_ier, wr_fcr, wr_lcr, wr_mcr, wr_scr;
    logic       rd_rbr, rd_iir, rd_lsr, rd_msr;
    logic       q_push, q_clear, q_empty, q_ovf;
    logic [7:0] q_data, q_head, rd_mux;
    logic [CNT_W-1:0] q_cnt;
    logic [3:0] cause;
    logic       cause_act;

    // Access decode with divisor-access remap of offsets 0 and 1.
    always_comb begin
        dlab    = lcr[7];
        loop_on = mcr[4];
        rd_any  = rd_en && !wr_en;
        wr_thr  = wr_en && addr == OFS_DATA && !dlab;
        wr_dll  = wr_en && addr == OFS_DATA && dlab;
        wr_ier  = wr_en && addr == OFS_IER && !dlab;
        wr_dlm  = wr_en && addr == OFS_IER && dlab;
        wr_fcr  = wr_en && addr == OFS_IIR;
        wr_lcr  = wr_en && addr == OFS_LCR;
        wr_mcr  = wr_en && addr == OFS_MCR;
        wr_scr  = wr_en && addr == OFS_SCR;
        rd_rbr  = rd_any && addr == OFS_DATA && !dlab;
        rd_iir  = rd_any && addr == OFS_IIR;
        rd_lsr  = rd_any && addr == OFS_LSR;
        rd_msr  = rd_any && addr == OFS_MSR;
    end

    // Receive queue feed: loopback data writes or external bytes.
    always_comb begin
        q_push  = loop_on ? wr_thr : rx_valid;
        q_data  = loop_on ? wdata : rx_byte;
        q_clear = wr_fcr && ((fcr[0] ^ wdata[0]) || (wdata[0] && wdata[1]));
    end

    serport_rxq #(
        .DATA_W (8),
        .DEPTH  (FIFO_DEPTH)
    ) u_rxq (
        .clk         (clk),
        .rst_n       (rst_n),
        .deep_i      (fcr[0]),
        .clear_i     (q_clear),
        .push_i      (q_push),
        .push_data_i (q_data),
        .pop_i       (rd_rbr),
        .head_o      (q_head),
        .empty_o     (q_empty),
        .overflow_o  (q_ovf),
        .count_o     (q_cnt)
    );

    serport_modem u_modem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mcr_i (wr_mcr),
        .wdata_i  (wdata),
        .rd_msr_i (rd_msr),
        .mcr_o    (mcr),
        .msr_o    (msr)
    );

    serport_cause u_cause (
        .ier_i       (ier[3:0]),
        .overrun_i   (lsr_oe),
        .rx_ready_i  (!q_empty),
        .thre_pend_i (thre_pend),
        .modem_chg_i (msr[3:0] != 4'h0),
        .cause_o     (cause),
        .active_o    (cause_act)
    );

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dll <= DIV_RESET[7:0];
            dlm <= DIV_RESET[15:8];
            ier <= 8'h00;
            lcr <= 8'h00;
            scr <= 8'h00;
            fcr <= 8'h00;
        end else begin
            if (wr_dll) dll <= wdata;
            if (wr_dlm) dlm <= wdata;
            if (wr_ier) ier <= wdata & 8'h0F;
            if (wr_lcr) lcr <= wdata;
            if (wr_scr) scr <= wdata;
            if (wr_fcr) fcr <= wdata[0] ? (wdata & 8'hC9) : 8'h00;
        end
    end

    // Sticky overrun and transmit-empty pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsr_oe    <= 1'b0;
            thre_pend <= 1'b0;
        end else begin
            if (rd_lsr) lsr_oe <= 1'b0;
            if (q_ovf)  lsr_oe <= 1'b1;
            if (wr_thr)
                thre_pend <= 1'b1;
            else if (rd_iir && cause == CAUSE_THRE)
                thre_pend <= 1'b0;
        end
    end

    // Read data selection from the pre-access state.
    always_comb begin
        unique case (addr)
            OFS_DATA: rd_mux = dlab ? dll : (q_empty ? 8'hFF : q_head);
            OFS_IER:  rd_mux = dlab ? dlm : ier;
            OFS_IIR:  rd_mux = {fcr[0] ? 2'b11 : 2'b00, 2'b00, cause};
            OFS_LCR:  rd_mux = lcr;
            OFS_MCR:  rd_mux = mcr;
            OFS_LSR:  rd_mux = {1'b0, 1'b1, 1'b1, 3'b000, lsr_oe, !q_empty};
            OFS_MSR:  rd_mux = msr;
            default:  rd_mux = scr;
        endcase
    end

    // Registered read data and transmit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= 8'h00;
            tx_valid <= 1'b0;
            tx_byte  <= 8'h00;
        end else begin
            if (rd_any) rdata <= rd_mux;
            tx_valid <= wr_thr && !loop_on;
            if (wr_thr && !loop_on) tx_byte <= wdata;
        end
    end

    // Level interrupt follows the selected cause.
    always_comb irq = cause_act;
endmodule

// File: rtl/serport_chk.sv
// Checker: temporal properties of the serial port register file, attached
// to the top module with a bind. Assumes one access per cycle.
module serport_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       wdata,
    input logic             rx_valid,
    input logic             tx_valid,
    input logic [7:0]       tx_byte,
    input logic             irq,
    input logic [7:0]       lcr,
    input logic [7:0]       mcr,
    input logic [7:0]       msr,
    input logic [7:0]       ier,
    input logic             lsr_oe,
    input logic             fcr_en,
    input logic [CNT_W-1:0] q_cnt
);
    p_tx_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !lcr[7] && !mcr[4]) |=> (tx_valid && tx_byte == $past(wdata)));

    p_no_tx_in_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mcr[4]) |=> !tx_valid);

    p_loop_drops_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mcr[4] && !wr_en && !rd_en) |=> $stable(q_cnt));

    p_oe_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd5 && !rx_valid) |=> !lsr_oe);

    p_delta_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd6) |=> (msr[3:0] == 4'h0));

    p_shallow_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fcr_en |-> (q_cnt <= CNT_W'(1)));

    p_ier_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && !lcr[7]) |=> (ier[7:4] == 4'h0));

    p_irq_on_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[0] && q_cnt != '0) |-> irq);
endmodule

bind serial_port_regs serport_chk #(
    .CNT_W ($clog2(FIFO_DEPTH + 1))
) u_serport_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .irq      (irq),
    .lcr      (lcr),
    .mcr      (mcr),
    .msr      (msr),
    .ier      (ier),
    .lsr_oe   (lsr_oe),
    .fcr_en   (fcr[0]),
    .q_cnt    (q_cnt)
);

// File: tb/test_serial_port_regs.sv
// Scoreboard bench: driver tasks queue expected read and transmit bytes,
// monitor processes compare them against the outputs on the falling edge.
module test_serial_port_regs;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] rd_exp_q[$];
    string      rd_tag_q[$];
    logic [7:0] tx_exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_port_regs i_serial_port_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .irq      (irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        #1 rd_en = 1'b0;
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        tx_exp_q.push_back(b);
        wr(3'd0, b);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        check(irq === exp, {tag, " irq"}, int'(irq), int'(exp));
    endtask

    // Read monitor: compare registered read data with the queued value.
    always @(negedge clk) begin
        if (rd_exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = rd_exp_q.pop_front();
            t = rd_tag_q.pop_front();
            check(rdata === e, t, int'(rdata), int'(e));
        end
    end

    // Transmit monitor: each strobe must match the next queued byte.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (tx_exp_q.size() > 0) begin
                logic [7:0] e;
                e = tx_exp_q.pop_front();
                check(tx_byte === e, "R4 tx_byte", int'(tx_byte), int'(e));
            end else begin
                check(1'b0, "R4 unexpected tx strobe", int'(tx_byte), -1);
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(3'd2, 8'h01, "R1 iir");
        rd(3'd5, 8'h60, "R1 lsr");
        rd(3'd1, 8'h00, "R1 ier");
        rd(3'd3, 8'h00, "R1 lcr");
        rd(3'd4, 8'h00, "R1 mcr");
        // R2 divisor access remap
        wr(3'd3, 8'h80);
        rd(3'd0, 8'h0C, "R1 R2 dll");
        rd(3'd1, 8'h00, "R1 R2 dlm");
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h56);
        rd(3'd0, 8'h34, "R2 dll");
        rd(3'd1, 8'h56, "R2 dlm");
        wr(3'd3, 8'h03);
        rd(3'd3, 8'h03, "R3 lcr");
        rd(3'd1, 8'h00, "R2 ier untouched");
        // R3 masking
        wr(3'd1, 8'hF0);
        rd(3'd1, 8'h00, "R3 ier");
        wr(3'd7, 8'hA5);
        rd(3'd7, 8'hA5, "R3 scr");
        // R9 R10 loopback mirror and change flags
        wr(3'd4, 8'hF3);
        rd(3'd4, 8'h13, "R3 mcr");
        rd(3'd6, 8'h33, "R9 R10 msr");
        rd(3'd6, 8'h30, "R10 msr cleared");
        wr(3'd4, 8'h1C);
        wr(3'd4, 8'h18);
        rd(3'd6, 8'h8F, "R10 teri kept");
        rd(3'd6, 8'h80, "R10 msr cleared");
        wr(3'd0, 8'h55);
        rx(8'h99);
        rd(3'd5, 8'h61, "R9 lsr");
        rd(3'd0, 8'h55, "R9 loop data");
        rd(3'd0, 8'hFF, "R13 empty");
        rd(3'd5, 8'h60, "R13 lsr");
        wr(3'd4, 8'h00);
        rd(3'd6, 8'h08, "R9 R10 exit loop");
        // R4 R6 transmit and THRE retire
        send(8'h3C);
        wr(3'd1, 8'h02);
        chk_irq(1'b1, "R12 thre");
        rd(3'd2, 8'h02, "R6 iir thre");
        chk_irq(1'b0, "R6 R12 retired");
        rd(3'd2, 8'h01, "R6 iir none");
        // R5 priority walk
        wr(3'd1, 8'h0F);
        rx(8'h11);
        chk_irq(1'b1, "R12 rx");
        rx(8'h22);
        rd(3'd2, 8'h06, "R5 line");
        send(8'h77);
        wr(3'd4, 8'h10);
        wr(3'd4, 8'h12);
        rd(3'd5, 8'h63, "R8 lsr oe");
        rd(3'd2, 8'h0C, "R5 rx");
        rd(3'd0, 8'h11, "R8 kept first");
        rd(3'd2, 8'h02, "R5 thre");
        rd(3'd2, 8'h00, "R5 modem");
        chk_irq(1'b1, "R12 modem");
        rd(3'd6, 8'h11, "R10 msr");
        rd(3'd2, 8'h01, "R5 none");
        chk_irq(1'b0, "R12 none");
        wr(3'd4, 8'h00);
        rd(3'd6, 8'h01, "R10 cts fall");
        wr(3'd1, 8'h00);
        // R7 deep queue
        wr(3'd2, 8'h01);
        rd(3'd2, 8'hC1, "R6 R7 fifo bits");
        for (int i = 0; i < 16; i++) rx(8'(i * 3 + 1));
        rd(3'd5, 8'h61, "R7 16 held");
        rx(8'hEE);
        rd(3'd5, 8'h63, "R7 R8 overrun at 17");
        for (int i = 0; i < 16; i++) rd(3'd0, 8'(i * 3 + 1), "R7 order");
        rd(3'd5, 8'h60, "R7 drained");
        rx(8'h44);
        rx(8'h45);
        wr(3'd2, 8'h03);
        rd(3'd5, 8'h60, "R7 rcv reset");
        rd(3'd0, 8'hFF, "R7 R13 empty");
        rx(8'h5A);
        wr(3'd2, 8'hC8);
        rd(3'd2, 8'h01, "R7 fcr zeroed");
        rd(3'd5, 8'h60, "R7 disable clears");
        rx(8'hA1);
        rx(8'hA2);
        rd(3'd5, 8'h63, "R7 R8 depth one");
        rd(3'd0, 8'hA1, "R7 depth one data");
        // R11 ignored writes
        wr(3'd5, 8'hFF);
        rd(3'd5, 8'h60, "R11 lsr");
        wr(3'd6, 8'hFF);
        rd(3'd6, 8'h00, "R11 msr");
        repeat (3) @(posedge clk);
        #1;
        check(tx_exp_q.size() == 0, "R4 tx count", tx_exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule